// File: doc/BRIEF.md
# Mode-Filtered Event Counter Bank

The block holds one to four 32-bit event counters. Each counter has a control word beside it. Software reaches both through a small register port: one write port and one combinational read port. On every clock cycle each counter looks at the event code in its control word and picks one strobe from the event inputs. It counts that strobe only when one of its enabled privilege modes matches the mode the processor is in now. The modes are user, supervisor, kernel and the exception level. Even-numbered and odd-numbered counters read separate strobe vectors, so one event code means different things on the two kinds. Two codes, cycles and instructions, come from a shared pair of strobes that every counter sees.

A counter counts as overflowed while its top bit is 1. If its interrupt enable is also set, it drives the single shared interrupt line. The same condition shows as a pending bit in a status word, which software reads before it services the interrupt. The handler clears the condition by writing the count back with the top bit off. A read-only chain bit in each control word tells software whether another counter follows. A fixed configuration word has a present bit. Together these let software find out how many counters exist.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all counts and control fields are 0 and `irq_o` is low.
- R2: The control word sits at address 2k and the count at address 2k+1. Control bits 14:0 can be written: bit 0 enables the exception-level mode, bit 1 kernel, bit 2 supervisor, bit 3 user, bit 4 the interrupt enable, and bits 14:5 hold the event code. Bits 30:15 read 0. Bit 31 reads 1 exactly when counter k+1 is implemented, and writes to it are ignored.
- R3: Kernel mode holds when `ksu_i` is 00, or `exl_i` is 1, or `erl_i` is 1. Outside kernel mode, `ksu_i`=01 is supervisor and 10 is user. The exception-level enable matches whenever `exl_i` is 1.
- R4: Event codes 0 and 1 select `evt_common_i[0]` and `evt_common_i[1]` on every counter. A code c from 2 to NUM_EVT-1 selects `evt_even_i[c]` on even counters and `evt_odd_i[c]` on odd counters. A code of NUM_EVT or above never counts.
- R5: A counter increases by exactly one in a cycle in which its selected strobe is high and at least one of its enabled modes matches. Otherwise it holds its value.
- R6: A write to a count takes priority over an increment of that count in the same cycle.
- R7: `irq_o` is the OR, over all counters, of (count bit 31 AND interrupt enable). It stays high until software clears that bit 31 or that enable.
- R8: The status word at address 9 carries `irq_o` in bit 26 and 0 in every other bit.
- R9: The configuration word at address 8 reads 0x00000010 (bit 4 shows that counters are present).
- R10: Addresses of counters at index NUM_CNT and above, and addresses 10 to 15, read 0. Writes to them are ignored.
- R11: A control word of 0 stops its counter whatever the events and mode are. A count written with 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| ksu_i | input | 2 | Current privilege field |
| exl_i | input | 1 | Exception level flag |
| erl_i | input | 1 | Error level flag |
| evt_common_i | input | 2 | Shared strobes for codes 0 and 1 |
| evt_even_i | input | NUM_EVT | Strobes seen by even counters |
| evt_odd_i | input | NUM_EVT | Strobes seen by odd counters |
| irq_o | output | 1 | Shared overflow interrupt, level |

## Verification
The bench is built with three counters. That makes the last chain bit clear and counter 3 unimplemented. A design that hardwires the chain bit, or that lets writes into the missing slot stick, shows a wrong read-back there. The directed cases cover the following:
- Supervisor enables under kernel mode, and the error-level flag overriding the user field. A loose mode decode counts in the wrong mode.
- Event code 5 driven only on the odd vector, then only on the even vector. A wrong parity selection gives swapped counts.
- A write landing in the same cycle as an event. Wrong priority leaves an off-by-one count.
- Overflow cleared first by masking bit 31 and then by dropping the enable. An edge-sensitive or latched interrupt stays high after either.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;
  localparam int MAX_CNT  = 4;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 10;
  localparam int ADDR_W   = 4;
  localparam int CTL_W    = 15;

  localparam int CTL_EXL  = 0;
  localparam int CTL_KERN = 1;
  localparam int CTL_SUP  = 2;
  localparam int CTL_USR  = 3;
  localparam int CTL_IE   = 4;
  localparam int CODE_LO  = 5;
  localparam int CODE_HI  = 14;
  localparam int MORE_BIT = 31;
  localparam int OVF_BIT  = 31;
  localparam int PEND_BIT = 26;
  localparam int PRES_BIT = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG   = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE = 4'd9;

  typedef struct packed {
    logic usr;
    logic sup;
    logic kern;
    logic exl;
  } mode_t;
endpackage

// File: rtl/perf_mode_decode.sv
module perf_mode_decode
  import perf_bank_pkg::*;
(
  input  logic [1:0] ksu_i,
  input  logic       exl_i,
  input  logic       erl_i,
  output mode_t      mode_o
);
  logic kern;

  always_comb begin
    kern        = (ksu_i == 2'b00) | exl_i | erl_i;
    mode_o.exl  = exl_i;
    mode_o.kern = kern;
    mode_o.sup  = ~kern & (ksu_i == 2'b01);
    mode_o.usr  = ~kern & (ksu_i == 2'b10);
  end

  always_comb begin
    AST_MODE_EXCL: assert ($onehot0({mode_o.kern, mode_o.sup, mode_o.usr})); // R3
  end
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
  import perf_bank_pkg::*;
#(
  parameter int NUM_EVT = 16
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [1:0]         evt_common_i,
  input  logic [NUM_EVT-1:0] evt_side_i,
  output logic               strobe_o
);
  localparam int IDX_W = $clog2(NUM_EVT);
  localparam logic [CODE_W-1:0] NUM_EVT_C = CODE_W'(NUM_EVT);

  always_comb begin
    if (code_i < CODE_W'(2))       strobe_o = evt_common_i[code_i[0]];
    else if (code_i < NUM_EVT_C)   strobe_o = evt_side_i[code_i[IDX_W-1:0]];
    else                           strobe_o = 1'b0;
  end
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice
  import perf_bank_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_we_i,
  input  logic               cnt_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  mode_t              mode_i,
  input  logic [1:0]         evt_common_i,
  input  logic [NUM_EVT-1:0] evt_side_i,
  output logic [DATA_W-1:0]  ctl_rd_o,
  output logic [DATA_W-1:0]  cnt_o,
  output logic               irq_req_o
);
  localparam logic MORE = (IDX < NUM_CNT - 1);

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] cnt_q;
  logic              strobe, mode_hit, count_en;

  perf_evt_sel #(.NUM_EVT(NUM_EVT)) i_sel (
    .code_i      (ctl_q[CODE_HI:CODE_LO]),
    .evt_common_i(evt_common_i),
    .evt_side_i  (evt_side_i),
    .strobe_o    (strobe)
  );

  assign mode_hit = |(ctl_q[CTL_USR:CTL_EXL] & mode_i);
  assign count_en = strobe & mode_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= wdata_i[CTL_W-1:0];
      if (cnt_we_i)      cnt_q <= wdata_i;  // write wins over event
      else if (count_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ctl_rd_o  = {MORE, {(DATA_W-CTL_W-1){1'b0}}, ctl_q};
  assign cnt_o     = cnt_q;
  assign irq_req_o = cnt_q[OVF_BIT] & ctl_q[CTL_IE];

  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_we_i |=> cnt_q == $past(wdata_i)); // R6
  AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!cnt_we_i && count_en) |=> cnt_q == $past(cnt_q) + 32'd1); // R5
  AST_NO_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (!cnt_we_i && !strobe) |=> $stable(cnt_q)); // R4
  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni) (!cnt_we_i && ctl_q[CTL_USR:CTL_EXL] == 4'b0) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_bank_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [1:0]         ksu_i,
  input  logic               exl_i,
  input  logic               erl_i,
  input  logic [1:0]         evt_common_i,
  input  logic [NUM_EVT-1:0] evt_even_i,
  input  logic [NUM_EVT-1:0] evt_odd_i,
  output logic               irq_o
);
  mode_t             mode;
  logic [DATA_W-1:0] ctl_rd [MAX_CNT];
  logic [DATA_W-1:0] cnt_rd [MAX_CNT];
  logic [MAX_CNT-1:0] irq_req;
  logic [1:0]        rd_idx;

  perf_mode_decode i_mode (
    .ksu_i (ksu_i),
    .exl_i (exl_i),
    .erl_i (erl_i),
    .mode_o(mode)
  );

  for (genvar k = 0; k < MAX_CNT; k++) begin : g_slot
    if (k < NUM_CNT) begin : g_impl
      logic ctl_we, cnt_we;
      assign ctl_we = wr_en_i && (wr_addr_i == ADDR_W'(2*k));
      assign cnt_we = wr_en_i && (wr_addr_i == ADDR_W'(2*k+1));

      perf_cnt_slice #(.IDX(k), .NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT)) i_slice (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctl_we_i    (ctl_we),
        .cnt_we_i    (cnt_we),
        .wdata_i     (wr_data_i),
        .mode_i      (mode),
        .evt_common_i(evt_common_i),
        .evt_side_i  ((k % 2 == 1) ? evt_odd_i : evt_even_i),
        .ctl_rd_o    (ctl_rd[k]),
        .cnt_o       (cnt_rd[k]),
        .irq_req_o   (irq_req[k])
      );

      AST_OVF_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni) (cnt_rd[k][OVF_BIT] && ctl_rd[k][CTL_IE]) |-> irq_o); // R7
    end else begin : g_none
      assign ctl_rd[k]  = '0;
      assign cnt_rd[k]  = '0;
      assign irq_req[k] = 1'b0;
    end
  end

  assign irq_o  = |irq_req;
  assign rd_idx = rd_addr_i[2:1];

  always_comb begin
    rd_data_o = '0;
    if (!rd_addr_i[3]) begin
      if (int'(rd_idx) < NUM_CNT) rd_data_o = rd_addr_i[0] ? cnt_rd[rd_idx] : ctl_rd[rd_idx];
    end else if (rd_addr_i == ADDR_CFG) begin
      rd_data_o[PRES_BIT] = 1'b1;
    end else if (rd_addr_i == ADDR_CAUSE) begin
      rd_data_o[PEND_BIT] = irq_o;
    end
  end

  AST_CAUSE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_addr_i == ADDR_CAUSE) |-> rd_data_o[PEND_BIT] == irq_o); // R8
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (!rd_addr_i[3] && int'(rd_idx) >= NUM_CNT) |-> rd_data_o == '0); // R10
  AST_RESET_QUIET: assert property (@(posedge clk_i) $rose(rst_ni) |-> !irq_o); // R1
endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N_CNT = 3;
  localparam int N_EVT = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [1:0]  ksu_i = 2'b10;
  logic        exl_i = 1'b0, erl_i = 1'b0;
  logic [1:0]  evt_common_i = '0;
  logic [N_EVT-1:0] evt_even_i = '0, evt_odd_i = '0;
  logic        irq_o;

  int errors = 0, checks = 0;
  logic [31:0] m_ctl [4];
  logic [31:0] m_cnt [4];
  logic [31:0] last_rd;
  logic        last_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_bank #(.NUM_CNT(N_CNT), .NUM_EVT(N_EVT)) i_perf_counter_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ksu_i(ksu_i), .exl_i(exl_i), .erl_i(erl_i), .evt_common_i(evt_common_i),
    .evt_even_i(evt_even_i), .evt_odd_i(evt_odd_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic exp_hit(int k, logic [31:0] c, logic [1:0] ksu, logic exl, logic erl,
                                   logic [1:0] cm, logic [N_EVT-1:0] ev, logic [N_EVT-1:0] od);
    logic kern, md, st;
    int code;
    kern = (ksu == 2'b00) || exl || erl;
    md = (c[0] && exl) || (c[1] && kern) || (c[2] && !kern && ksu == 2'b01) ||
         (c[3] && !kern && ksu == 2'b10);
    code = int'(c[14:5]);
    if (code < 2) st = cm[code];
    else if (code < N_EVT) st = (k % 2 == 1) ? od[code] : ev[code];
    else st = 1'b0;
    return md && st;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int k = 0; k < N_CNT; k++) r |= m_cnt[k][31] & m_ctl[k][4];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    int idx = int'(a[2:1]);
    if (a == 4'd8) return 32'h10;
    if (a == 4'd9) return {5'b0, exp_irq(), 26'b0};
    if (a[3] || idx >= N_CNT) return 32'h0;
    if (a[0]) return m_cnt[idx];
    return m_ctl[idx] | ((idx < N_CNT - 1) ? 32'h8000_0000 : 32'h0);
  endfunction

  function automatic string tag_of(logic [3:0] a);
    if (a == 4'd8) return "R9";
    if (a == 4'd9) return "R8";
    if (a[3] || int'(a[2:1]) >= N_CNT) return "R10";
    return a[0] ? "R5" : "R2";
  endfunction

  task automatic step(input logic we, input logic [3:0] wa, input logic [31:0] wd, input logic [3:0] ra,
                      input logic [1:0] ksu, input logic exl, input logic erl, input logic [1:0] cm,
                      input logic [N_EVT-1:0] ev, input logic [N_EVT-1:0] od);
    logic [31:0] nctl [4];
    logic [31:0] ncnt [4];
    @(negedge clk);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    ksu_i = ksu; exl_i = exl; erl_i = erl;
    evt_common_i = cm; evt_even_i = ev; evt_odd_i = od;
    #1;
    last_rd = rd_data_o;
    last_irq = irq_o;
    check(tag_of(ra), last_rd, exp_rd(ra));
    check("R7", {31'b0, last_irq}, {31'b0, exp_irq()});
    for (int k = 0; k < 4; k++) begin
      nctl[k] = m_ctl[k];
      ncnt[k] = m_cnt[k];
      if (k < N_CNT) begin
        if (we && wa == 4'(2*k)) nctl[k] = wd & 32'h0000_7FFF;
        if (we && wa == 4'(2*k+1)) ncnt[k] = wd;
        else if (exp_hit(k, m_ctl[k], ksu, exl, erl, cm, ev, od)) ncnt[k] = m_cnt[k] + 32'd1;
      end
    end
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      m_ctl[k] = nctl[k];
      m_cnt[k] = ncnt[k];
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, 4'd0, 2'b10, 1'b0, 1'b0, 2'b00, '0, '0);
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, 4'd0, 32'd0, a, 2'b10, 1'b0, 1'b0, 2'b00, '0, '0);
    check(tag, last_rd, exp);
  endtask

  task automatic ev_step(input logic [1:0] ksu, input logic exl, input logic erl, input logic [1:0] cm,
                         input logic [N_EVT-1:0] ev, input logic [N_EVT-1:0] od);
    step(1'b0, 4'd0, 32'd0, 4'd0, ksu, exl, erl, cm, ev, od);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int k = 0; k < 4; k++) begin m_ctl[k] = '0; m_cnt[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state, chain bits
    rd_exp(4'd0, 32'h8000_0000, "R1");
    rd_exp(4'd1, 32'h0, "R1");
    rd_exp(4'd2, 32'h8000_0000, "R1");
    rd_exp(4'd3, 32'h0, "R1");
    rd_exp(4'd4, 32'h0, "R1");
    rd_exp(4'd5, 32'h0, "R1");
    check("R1", {31'b0, last_irq}, 32'h0);
    rd_exp(4'd8, 32'h0000_0010, "R9");

    // R2 writable field and read-only chain bit
    wr(4'd0, 32'hFFFF_FFFF);
    rd_exp(4'd0, 32'h8000_7FFF, "R2");
    wr(4'd4, 32'hFFFF_FFFF);
    rd_exp(4'd4, 32'h0000_7FFF, "R2");

    // R10 unimplemented slot ignores writes
    wr(4'd6, 32'h1234_5678);
    wr(4'd7, 32'h1234_5678);
    wr(4'd11, 32'hFFFF_FFFF);
    rd_exp(4'd6, 32'h0, "R10");
    rd_exp(4'd7, 32'h0, "R10");
    rd_exp(4'd11, 32'h0, "R10");

    // R3 user-only counter, erl and ksu=00 force kernel
    wr(4'd4, 32'h0); wr(4'd0, 32'h0000_0008); wr(4'd1, 32'h0);
    ev_step(2'b10, 1'b0, 1'b0, 2'b01, '0, '0);
    ev_step(2'b10, 1'b0, 1'b1, 2'b01, '0, '0);
    ev_step(2'b00, 1'b0, 1'b0, 2'b01, '0, '0);
    rd_exp(4'd1, 32'd1, "R3");
    // R3 supervisor-only counter, exl makes it kernel
    wr(4'd2, 32'h0000_0024); wr(4'd3, 32'h0);
    ev_step(2'b01, 1'b0, 1'b0, 2'b10, '0, '0);
    ev_step(2'b01, 1'b1, 1'b0, 2'b10, '0, '0);
    rd_exp(4'd3, 32'd1, "R3");

    // R4 parity-dependent event decode
    wr(4'd0, 32'h0000_00A2); wr(4'd2, 32'h0000_00A2);
    wr(4'd1, 32'h0); wr(4'd3, 32'h0);
    ev_step(2'b00, 1'b0, 1'b0, 2'b00, 16'h0020, 16'h0000);
    ev_step(2'b00, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0020);
    ev_step(2'b00, 1'b0, 1'b0, 2'b11, 16'h0000, 16'h0000);
    rd_exp(4'd1, 32'd1, "R4");
    rd_exp(4'd3, 32'd1, "R4");
    wr(4'd4, 32'h0000_0282); wr(4'd5, 32'h0);
    ev_step(2'b00, 1'b1, 1'b1, 2'b11, 16'hFFFF, 16'hFFFF);
    rd_exp(4'd5, 32'd0, "R4");

    // R6 write beats a same-cycle event
    wr(4'd0, 32'h0000_0002);
    step(1'b1, 4'd1, 32'd100, 4'd0, 2'b00, 1'b0, 1'b0, 2'b01, '0, '0);
    rd_exp(4'd1, 32'd100, "R6");
    // R5 one per event cycle
    for (int i = 0; i < 5; i++) ev_step(2'b00, 1'b0, 1'b0, 2'b01, '0, '0);
    rd_exp(4'd1, 32'd105, "R5");

    // R7 / R8 overflow interrupt
    wr(4'd1, 32'h7FFF_FFFF); wr(4'd0, 32'h0000_0012);
    rd_exp(4'd9, 32'h0, "R8");
    ev_step(2'b00, 1'b0, 1'b0, 2'b01, '0, '0);
    rd_exp(4'd9, 32'h0400_0000, "R8");
    check("R7", {31'b0, last_irq}, 32'h1);
    rd_exp(4'd9, 32'h0400_0000, "R7");
    wr(4'd1, 32'h0000_0005);
    rd_exp(4'd9, 32'h0, "R7");
    check("R7", {31'b0, last_irq}, 32'h0);
    wr(4'd1, 32'h8000_0000);
    rd_exp(4'd9, 32'h0400_0000, "R7");
    wr(4'd0, 32'h0000_0002);
    rd_exp(4'd9, 32'h0, "R7");
    rd_exp(4'd1, 32'h8000_0000, "R7");

    // R11 zero control stops counting, zero count clears
    wr(4'd0, 32'h0);
    ev_step(2'b00, 1'b1, 1'b1, 2'b11, 16'hFFFF, 16'hFFFF);
    ev_step(2'b10, 1'b0, 1'b0, 2'b11, 16'hFFFF, 16'hFFFF);
    rd_exp(4'd1, 32'h8000_0000, "R11");
    wr(4'd1, 32'h0);
    rd_exp(4'd1, 32'h0, "R11");

    // random traffic against the bench model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      case ($urandom % 4)
        0: d = $urandom;
        1: d = 32'h7FFF_FFF0 + ($urandom % 16);
        2: d = ($urandom % 32) | (($urandom % 20) << 5);
        default: d = 32'h0;
      endcase
      step(($urandom % 4) == 0, 4'($urandom % 12), d, 4'($urandom % 16),
           2'($urandom), 1'(($urandom % 5) == 0), 1'(($urandom % 7) == 0),
           2'($urandom), N_EVT'($urandom), N_EVT'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule